// File: doc/BRIEF.md
# Coverage-Mask Front-to-Back Tile Compositor

This block takes the fragments that an upstream selection stage has already put in front-to-back order for one screen tile. It folds each one into the running result for its pixel. For every pixel it keeps only a 40-bit word: three colour channels, an accumulated alpha and an 8-sample coverage mask. It keeps no per-layer history. Each fragment carries a one-bit mode that picks between two blend functions:

- **Layer blend.** The new fragment only fills samples that are still uncovered.
- **Same-surface merge.** Two pieces of one tessellated surface are averaged by how many samples each one covers.

Storage is split into two tile banks. When the upstream stage signals the end of a tile, the banks swap. The finished tile is then streamed out pixel by pixel as final colour, while the next tile is composited into the other, freshly cleared bank. Every fragment also produces an immediate copy of the updated 40-bit pixel word, so downstream logic can observe the running result.

Top module: `covmask_compositor`

## Requirements
- R1: After reset no record or readout output is valid, and every pixel of the open tile holds the all-zero word.
- R2: A pixel word is laid out as red [39:32], green [31:24], blue [23:16], alpha [15:8], mask [7:0]. A fragment sampled on a clock edge produces `rec_valid`, `rec_pix` equal to the fragment's pixel, and the updated word, all registered on that same edge. `rec_valid` is low in cycles with no fragment.
- R3: Layer blend (`frag_merge` = 0). Let n be the number of ones in (fragment mask AND NOT stored mask), and let the weight w = (alpha·n + 4) div 8. Each colour channel becomes min(255, stored + (src·w + 127) div 255). Alpha becomes min(255, stored alpha + w). The mask becomes stored OR fragment.
- R4: A layer-blend fragment that adds no new samples leaves colour and alpha unchanged, and leaves the mask as stored OR fragment.
- R5: Same-surface merge (`frag_merge` = 1). Let p = popcount(stored mask), q = popcount(fragment mask) and d = p + q. Each colour channel and the alpha become (stored·p + src·q + d div 2) div d, or 0 when d is 0. The mask becomes stored OR fragment.
- R6: A pixel whose stored mask is 8'hFF and whose alpha is 255 ignores further fragments in the tile. Its reported word equals the stored one.
- R7: Fragments to the same pixel on consecutive cycles each see the result of the previous one.
- R8: `tile_done` while no readout runs closes the tile. For the k-th clock edge after the accepting edge (k = 1 … tile size), the outputs after that edge carry `out_valid` = 1, `out_pix` = k−1 and `out_rgb` = bits [39:16] of that pixel's final word. Pixels never written read as 0. Afterwards `out_valid` returns to 0.
- R9: Fragments after the accepting edge, including those that arrive while the readout is running, composite onto an all-zero word in the new tile.
- R10: `tile_done` while a readout is running is ignored. The open tile stays open and no second stream starts.
- R11: A fragment presented in the same cycle as an accepted `tile_done` belongs to the tile being closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frag_valid | input | 1 | A fragment is presented this cycle |
| frag_pix | input | AW (9) | Pixel index within the tile |
| frag_rgb | input | 24 | Fragment colour, red in the top byte |
| frag_alpha | input | 8 | Fragment alpha |
| frag_mask | input | 8 | Fragment coverage, one bit per sample |
| frag_merge | input | 1 | 0 = layer blend, 1 = same-surface merge |
| tile_done | input | 1 | Close the open tile and start its readout |
| rec_valid | output | 1 | Updated pixel word is valid |
| rec_pix | output | AW (9) | Pixel index of the updated word |
| rec_word | output | 40 | Updated 40-bit pixel word |
| out_valid | output | 1 | Readout pixel valid |
| out_pix | output | AW (9) | Readout pixel index |
| out_rgb | output | 24 | Final colour of the readout pixel |

## Verification
The updated pixel word is due one clock after a fragment is sampled. Readout pixel k−1 is due after the k-th rising edge that follows the edge accepting `tile_done`. The bench drives every input at a falling edge and waits for the next rising edge. At that edge it advances its own model, including whether `tile_done` is accepted given the model's readout state. It then compares both output groups at the following falling edge. This cycle-exact model lets fragments, tile closure and the readout overlap in any mix while every cycle is still compared.

// File: rtl/cmc_pkg.sv
// cmc_pkg: shared widths, the packed pixel record and the per-channel
// blend arithmetic used by the coverage-mask compositor.
// Assumes 8-bit unsigned channels and an 8-sample mask.
package cmc_pkg;

    localparam int CH_W   = 8;
    localparam int MASK_W = 8;
    localparam int CH_MAX = (1 << CH_W) - 1;
    localparam int REC_W  = 4 * CH_W + MASK_W;
    localparam int CNT_W  = $clog2(MASK_W + 1);
    localparam int PRD_W  = 2 * CH_W + 1;
    localparam int MRG_W  = CH_W + CNT_W + 1;

    // One pixel's whole compositing state, red in the top byte.
    typedef struct packed {
        logic [CH_W-1:0]   r;
        logic [CH_W-1:0]   g;
        logic [CH_W-1:0]   b;
        logic [CH_W-1:0]   a;
        logic [MASK_W-1:0] m;
    } cmc_rec_t;

    // Number of covered samples in a mask.
    function automatic logic [CNT_W-1:0] popcnt(input logic [MASK_W-1:0] v);
        logic [CNT_W-1:0] s;
        s = '0;
        for (int i = 0; i < MASK_W; i++) s = s + CNT_W'(v[i]);
        return s;
    endfunction

    // Layer weight: alpha scaled by the fraction of fresh samples, rounded.
    function automatic logic [CH_W-1:0] fresh_weight(input logic [CH_W-1:0] alpha,
                                                     input logic [CNT_W-1:0] n);
        logic [MRG_W-1:0] t;
        t = MRG_W'(alpha) * MRG_W'(n) + MRG_W'(MASK_W / 2);
        t = t / MRG_W'(MASK_W);
        return t[CH_W-1:0];
    endfunction

    // Saturating add of two channel values.
    function automatic logic [CH_W-1:0] sat_add(input logic [CH_W-1:0] x,
                                                input logic [CH_W-1:0] y);
        logic [CH_W:0] t;
        t = (CH_W+1)'(x) + (CH_W+1)'(y);
        return t[CH_W] ? CH_W'(CH_MAX) : t[CH_W-1:0];
    endfunction

    // Layer blend of one colour channel: acc + round(src*w/255), saturated.
    function automatic logic [CH_W-1:0] layer_ch(input logic [CH_W-1:0] acc,
                                                 input logic [CH_W-1:0] src,
                                                 input logic [CH_W-1:0] wt);
        logic [PRD_W-1:0] p;
        p = PRD_W'(src) * PRD_W'(wt) + PRD_W'(CH_MAX / 2);
        p = p / PRD_W'(CH_MAX);
        return sat_add(acc, p[CH_W-1:0]);
    endfunction

    // Coverage-weighted average of two channel values, rounded to nearest.
    function automatic logic [CH_W-1:0] merge_ch(input logic [CH_W-1:0]  acc,
                                                 input logic [CH_W-1:0]  src,
                                                 input logic [CNT_W-1:0] pa,
                                                 input logic [CNT_W-1:0] ps);
        logic [MRG_W-1:0] num;
        logic [MRG_W-1:0] den;
        num = MRG_W'(acc) * MRG_W'(pa) + MRG_W'(src) * MRG_W'(ps);
        den = MRG_W'(pa) + MRG_W'(ps);
        if (den == '0) return '0;
        num = (num + (den >> 1)) / den;
        return num[CH_W-1:0];
    endfunction

endpackage

// File: rtl/cmc_blend.sv
// cmc_blend: combinational update of one pixel record with one fragment.
// Picks layer blend or same-surface merge from a single mode bit, and
// passes the record through untouched once the pixel is fully opaque.
// Assumes the caller presents the currently stored record.
module cmc_blend
    import cmc_pkg::*;
(
    input  cmc_rec_t                old_rec,
    input  logic [3*CH_W-1:0]       src_rgb,
    input  logic [CH_W-1:0]         src_a,
    input  logic [MASK_W-1:0]       src_m,
    input  logic                    merge,
    output cmc_rec_t                new_rec,
    output logic                    locked
);

    localparam int NCH = 3;

    logic [CH_W-1:0]   old_ch [NCH];
    logic [CH_W-1:0]   src_ch [NCH];
    logic [CH_W-1:0]   lay_ch [NCH];
    logic [CH_W-1:0]   mrg_ch [NCH];
    logic [MASK_W-1:0] fresh;
    logic [CNT_W-1:0]  n_fresh;
    logic [CNT_W-1:0]  n_old;
    logic [CNT_W-1:0]  n_src;
    logic [CH_W-1:0]   wt;

    // Unpack the stored colour so the channel loop can index it.
    assign old_ch[0] = old_rec.r;
    assign old_ch[1] = old_rec.g;
    assign old_ch[2] = old_rec.b;

    // Coverage counts and the layer weight shared by all channels.
    assign fresh   = src_m & ~old_rec.m;
    assign n_fresh = popcnt(fresh);
    assign n_old   = popcnt(old_rec.m);
    assign n_src   = popcnt(src_m);
    assign wt      = fresh_weight(src_a, n_fresh);
    assign locked  = (&old_rec.m) && (old_rec.a == CH_W'(CH_MAX));

    // Per-channel arithmetic for both blend functions.
    for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
        assign src_ch[gc] = src_rgb[(NCH-1-gc)*CH_W +: CH_W];
        assign lay_ch[gc] = layer_ch(old_ch[gc], src_ch[gc], wt);
        assign mrg_ch[gc] = merge_ch(old_ch[gc], src_ch[gc], n_old, n_src);
    end

    // Select the result according to the lock state and the mode bit.
    always_comb begin
        new_rec = old_rec;
        if (!locked) begin
            new_rec.m = old_rec.m | src_m;
            if (merge) begin
                new_rec.r = mrg_ch[0];
                new_rec.g = mrg_ch[1];
                new_rec.b = mrg_ch[2];
                new_rec.a = merge_ch(old_rec.a, src_a, n_old, n_src);
            end else begin
                new_rec.r = lay_ch[0];
                new_rec.g = lay_ch[1];
                new_rec.b = lay_ch[2];
                new_rec.a = sat_add(old_rec.a, wt);
            end
        end
    end

endmodule

// File: rtl/cmc_tile_store.sv
// cmc_tile_store: two banks of per-pixel records with a written flag per
// pixel. A whole bank is emptied in one cycle by clearing its flags; an
// unwritten pixel reads as the zero record. Two asynchronous read ports,
// one write port. Assumes a bank is never written and cleared together.
module cmc_tile_store
    import cmc_pkg::*;
#(
    parameter int PIX = 512,
    parameter int AW  = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_bank,
    input  logic [AW-1:0]   wr_addr,
    input  cmc_rec_t        wr_data,
    input  logic            clr_en,
    input  logic            clr_bank,
    input  logic            ra_bank,
    input  logic [AW-1:0]   ra_addr,
    output cmc_rec_t        ra_data,
    input  logic            rb_bank,
    input  logic [AW-1:0]   rb_addr,
    output cmc_rec_t        rb_data
);

    localparam int NBANK = 2;

    cmc_rec_t         mem [NBANK][PIX];
    logic [PIX-1:0]   vld [NBANK];

    for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
        // Record payload: written on a hit, never reset (flags gate it).
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(gb))) mem[gb][wr_addr] <= wr_data;
        end

        // Written flags: cleared on reset or bank clear, set on a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[gb] <= '0;
            end else begin
                if (clr_en && (clr_bank == 1'(gb))) vld[gb] <= '0;
                if (wr_en && (wr_bank == 1'(gb)))   vld[gb][wr_addr] <= 1'b1;
            end
        end
    end

    // Read ports: zero record for a pixel not written in this tile.
    assign ra_data = vld[ra_bank][ra_addr] ? mem[ra_bank][ra_addr] : '0;
    assign rb_data = vld[rb_bank][rb_addr] ? mem[rb_bank][rb_addr] : '0;

    // A clear and a write never land in the same bank in one cycle.
    assert_clear_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> !(wr_en && (wr_bank == clr_bank)));

endmodule

// File: rtl/cmc_readout.sv
// cmc_readout: streams the colour of every pixel of a closed tile, one per
// cycle in ascending index order, from the bank given at start. Ignores
// start while a stream is running. Output is registered.
module cmc_readout
    import cmc_pkg::*;
#(
    parameter int PIX = 512,
    parameter int AW  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_bank,
    output logic              busy,
    output logic              rd_bank,
    output logic [AW-1:0]     rd_addr,
    input  cmc_rec_t          rd_data,
    output logic              out_valid,
    output logic [AW-1:0]     out_pix,
    output logic [3*CH_W-1:0] out_rgb
);

    localparam logic [AW-1:0] LAST = AW'(PIX - 1);

    logic [AW-1:0] cnt;

    assign rd_addr = cnt;

    // Stream sequencer: latch the bank on start, step until the last pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            rd_bank <= 1'b0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            cnt     <= '0;
            rd_bank <= start_bank;
        end else if (busy) begin
            if (cnt == LAST) busy <= 1'b0;
            cnt <= cnt + AW'(1);
        end
    end

    // Output register: one pixel colour per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
            out_rgb   <= '0;
        end else begin
            out_valid <= busy;
            out_pix   <= cnt;
            out_rgb   <= {rd_data.r, rd_data.g, rd_data.b};
        end
    end

    // Consecutive readout pixels have consecutive indices.
    assert_pix_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_pix == $past(out_pix) + AW'(1)));

    // A stream always begins with pixel zero.
    assert_stream_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_pix == '0));

endmodule

// File: rtl/covmask_compositor.sv
// covmask_compositor: front-to-back coverage-mask compositor for one tile.
// Each fragment is read-modified-written into the open bank in one cycle,
// and the updated 40-bit word is reported one cycle later. tile_done swaps
// banks (when no readout runs), clears the new open bank and streams the
// closed bank's final colours. Assumes fragments arrive in depth order.
module covmask_compositor
    import cmc_pkg::*;
#(
    parameter  int TILE_W = 16,
    parameter  int TILE_H = 32,
    localparam int PIX    = TILE_W * TILE_H,
    localparam int AW     = $clog2(PIX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frag_valid,
    input  logic [AW-1:0]     frag_pix,
    input  logic [23:0]       frag_rgb,
    input  logic [7:0]        frag_alpha,
    input  logic [7:0]        frag_mask,
    input  logic              frag_merge,
    input  logic              tile_done,
    output logic              rec_valid,
    output logic [AW-1:0]     rec_pix,
    output logic [39:0]       rec_word,
    output logic              out_valid,
    output logic [AW-1:0]     out_pix,
    output logic [23:0]       out_rgb
);

    logic     open_bank;
    logic     ro_busy;
    logic     ro_bank;
    logic [AW-1:0] ro_addr;
    logic     accept;
    logic     locked;
    cmc_rec_t old_rec;
    cmc_rec_t new_rec;
    cmc_rec_t ro_rec;

    assign accept = tile_done && !ro_busy;

    // Open-bank pointer: flips each time a tile is closed.
    always_ff @(posedge clk) begin
        if (!rst_n)      open_bank <= 1'b0;
        else if (accept) open_bank <= ~open_bank;
    end

    cmc_tile_store #(.PIX(PIX), .AW(AW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (frag_valid),
        .wr_bank  (open_bank),
        .wr_addr  (frag_pix),
        .wr_data  (new_rec),
        .clr_en   (accept),
        .clr_bank (~open_bank),
        .ra_bank  (open_bank),
        .ra_addr  (frag_pix),
        .ra_data  (old_rec),
        .rb_bank  (ro_bank),
        .rb_addr  (ro_addr),
        .rb_data  (ro_rec)
    );

    cmc_blend u_blend (
        .old_rec (old_rec),
        .src_rgb (frag_rgb),
        .src_a   (frag_alpha),
        .src_m   (frag_mask),
        .merge   (frag_merge),
        .new_rec (new_rec),
        .locked  (locked)
    );

    cmc_readout #(.PIX(PIX), .AW(AW)) u_readout (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_bank (open_bank),
        .busy       (ro_busy),
        .rd_bank    (ro_bank),
        .rd_addr    (ro_addr),
        .rd_data    (ro_rec),
        .out_valid  (out_valid),
        .out_pix    (out_pix),
        .out_rgb    (out_rgb)
    );

    // Record report register: mirrors each write one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid <= 1'b0;
            rec_pix   <= '0;
            rec_word  <= '0;
        end else begin
            rec_valid <= frag_valid;
            rec_pix   <= frag_pix;
            rec_word  <= new_rec;
        end
    end

    // Every fragment yields a report on the next cycle.
    assert_rec_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frag_valid |=> rec_valid);

    // Coverage never shrinks: the reported mask keeps all stored samples.
    assert_mask_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frag_valid |=> ((rec_word[7:0] & $past(old_rec.m)) == $past(old_rec.m)));

    // A saturated pixel reports its stored word unchanged.
    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && locked) |=> (rec_word == $past(old_rec)));

    // A tile_done during a running stream leaves the open bank in place.
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tile_done && ro_busy) |=> $stable(open_bank));

endmodule

// File: tb/covmask_compositor_tb.sv
`timescale 1ns/1ps
module covmask_compositor_tb;

    localparam int TW  = 16;
    localparam int TH  = 32;
    localparam int PIX = TW * TH;
    localparam int AW  = $clog2(PIX);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frag_valid = 1'b0;
    logic [AW-1:0] frag_pix = '0;
    logic [23:0]   frag_rgb = '0;
    logic [7:0]    frag_alpha = '0;
    logic [7:0]    frag_mask = '0;
    logic          frag_merge = 1'b0;
    logic          tile_done = 1'b0;
    logic          rec_valid;
    logic [AW-1:0] rec_pix;
    logic [39:0]   rec_word;
    logic          out_valid;
    logic [AW-1:0] out_pix;
    logic [23:0]   out_rgb;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Bench model state.
    logic [39:0] cur  [PIX];
    logic [39:0] snap [PIX];
    bit          rb_busy = 0;
    int          rb_cnt = 0;

    always #4 clk = ~clk;

    covmask_compositor #(.TILE_W(TW), .TILE_H(TH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .frag_valid(frag_valid), .frag_pix(frag_pix), .frag_rgb(frag_rgb),
        .frag_alpha(frag_alpha), .frag_mask(frag_mask), .frag_merge(frag_merge),
        .tile_done(tile_done),
        .rec_valid(rec_valid), .rec_pix(rec_pix), .rec_word(rec_word),
        .out_valid(out_valid), .out_pix(out_pix), .out_rgb(out_rgb)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Expected pixel word after one fragment, straight from R3..R6.
    function automatic logic [39:0] ref_blend(input logic [39:0] o, input logic [23:0] c,
                                              input logic [7:0] a, input logic [7:0] m,
                                              input bit md);
        logic [39:0] r;
        int n, w, po, pn, den, v;
        if (o[7:0] == 8'hFF && o[15:8] == 8'hFF) return o;
        r = o;
        r[7:0] = o[7:0] | m;
        if (!md) begin
            n = $countones(m & ~o[7:0]);
            w = (int'(a) * n + 4) / 8;
            for (int i = 0; i < 3; i++) begin
                v = int'(o[39-8*i -: 8]) + (int'(c[23-8*i -: 8]) * w + 127) / 255;
                if (v > 255) v = 255;
                r[39-8*i -: 8] = v[7:0];
            end
            v = int'(o[15:8]) + w;
            if (v > 255) v = 255;
            r[15:8] = v[7:0];
        end else begin
            po = $countones(o[7:0]);
            pn = $countones(m);
            den = po + pn;
            for (int i = 0; i < 3; i++) begin
                v = (den == 0) ? 0 :
                    (int'(o[39-8*i -: 8]) * po + int'(c[23-8*i -: 8]) * pn + den / 2) / den;
                r[39-8*i -: 8] = v[7:0];
            end
            v = (den == 0) ? 0 : (int'(o[15:8]) * po + int'(a) * pn + den / 2) / den;
            r[15:8] = v[7:0];
        end
        return r;
    endfunction

    // One clock: drive at the falling edge, model at the rising edge, check after.
    task automatic step(input bit v, input int pix, input logic [23:0] rgb,
                        input logic [7:0] a, input logic [7:0] m, input bit md,
                        input bit done, input string note);
        logic [39:0] e_rec;
        bit          e_ov, was_busy, acc;
        int          e_op;
        logic [23:0] e_orgb;
        string       rtag;
        frag_valid = v; frag_pix = AW'(pix); frag_rgb = rgb; frag_alpha = a;
        frag_mask = m; frag_merge = md; tile_done = done;
        e_rec = '0; e_ov = 0; e_op = 0; e_orgb = '0; rtag = "R2";
        @(posedge clk);
        was_busy = rb_busy;
        acc = done && !was_busy;
        if (rb_busy) begin
            e_ov = 1; e_op = rb_cnt; e_orgb = snap[rb_cnt][39:16];
            if (rb_cnt == PIX - 1) rb_busy = 0;
            else rb_cnt++;
        end
        if (v) begin
            if (cur[pix][7:0] == 8'hFF && cur[pix][15:8] == 8'hFF) rtag = "R6";
            else if (md) rtag = "R5";
            else if ((m & ~cur[pix][7:0]) == 8'h00) rtag = "R4";
            else rtag = "R3";
            e_rec = ref_blend(cur[pix], rgb, a, m, md);
            cur[pix] = e_rec;
        end
        if (acc) begin
            for (int i = 0; i < PIX; i++) begin snap[i] = cur[i]; cur[i] = '0; end
            rb_busy = 1; rb_cnt = 0;
        end
        if (note != "") rtag = note;
        @(negedge clk);
        chk(rec_valid == v, rtag, "rec_valid", 64'(rec_valid), 64'(v));
        if (v) begin
            chk(rec_pix == AW'(pix), rtag, "rec_pix", 64'(rec_pix), 64'(pix));
            chk(rec_word == e_rec, rtag, "rec_word", 64'(rec_word), 64'(e_rec));
        end
        chk(out_valid == e_ov, (note != "") ? note : "R8", "out_valid",
            64'(out_valid), 64'(e_ov));
        if (e_ov) begin
            chk(out_pix == AW'(e_op), "R8", "out_pix", 64'(out_pix), 64'(e_op));
            chk(out_rgb == e_orgb, "R8", "out_rgb", 64'(out_rgb), 64'(e_orgb));
        end
    endtask

    task automatic idle(input int n, input string note);
        for (int i = 0; i < n; i++) step(0, 0, '0, '0, '0, 0, 0, note);
    endtask

    task automatic rnd_frag(input int lo, input int hi, input string note);
        logic [7:0] a, m;
        a = ($urandom_range(0, 1) == 1) ? 8'hFF : 8'($urandom);
        m = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
        step(1, $urandom_range(lo, hi), 24'($urandom), a, m,
             ($urandom_range(0, 3) == 0), 0, note);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        for (int i = 0; i < PIX; i++) begin cur[i] = '0; snap[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: nothing valid straight out of reset.
        chk(rec_valid == 1'b0, "R1", "rec_valid after reset", 64'(rec_valid), 64'd0);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);

        // R3 saturation, then R6 lock on a fully covered opaque pixel.
        step(1, 3, 24'hFFFFFF, 8'hFF, 8'h0F, 0, 0, "R3");
        step(1, 3, 24'hFFFFFF, 8'hFF, 8'hF0, 0, 0, "R3");
        step(1, 3, 24'h00FF00, 8'h80, 8'hFF, 1, 0, "R6");
        step(1, 3, 24'h123456, 8'h10, 8'h01, 0, 0, "R6");
        // R4: layer fragment with no fresh samples.
        step(1, 4, 24'h804020, 8'hC0, 8'h33, 0, 0, "");
        step(1, 4, 24'hFFFFFF, 8'hFF, 8'h21, 0, 0, "R4");
        // R5: empty merge, then merges weighted by coverage.
        step(1, 5, 24'hABCDEF, 8'h77, 8'h00, 1, 0, "R5");
        step(1, 5, 24'h902010, 8'hA0, 8'h03, 1, 0, "R5");
        step(1, 5, 24'h10F030, 8'h40, 8'h3C, 1, 0, "R5");
        // R7: back-to-back fragments on one pixel.
        step(1, 9, 24'h336699, 8'h90, 8'h81, 0, 0, "R7");
        step(1, 9, 24'hC08040, 8'hFF, 8'h0F, 0, 0, "R7");
        step(1, 9, 24'h204060, 8'h60, 8'hF0, 1, 0, "R7");

        for (int i = 0; i < 300; i++) rnd_frag(0, 15, "");

        // R11: fragment in the cycle that closes the tile.
        step(1, 20, 24'hFEDCBA, 8'hB0, 8'h5A, 0, 1, "R11");
        // R9 / R10: new tile fills while the stream runs; a second close is ignored.
        for (int i = 0; i < 120; i++) rnd_frag(0, 31, "R9");
        step(1, 40, 24'h0A0B0C, 8'hFF, 8'hFF, 0, 1, "R10");
        for (int i = 0; i < 60; i++) rnd_frag(0, 31, "R9");
        idle(PIX - 170, "");
        for (int i = 0; i < 30; i++) rnd_frag(0, 63, "R9");
        step(0, 0, '0, '0, '0, 0, 1, "R8");
        idle(PIX + 4, "");

        finished = 1;
        summary();
        $finish;
    end

endmodule